// File: doc/BRIEF.md
# CSR Access and Privilege Unit

This block carries out the read-modify-write operations of the control and status register instructions against four registers: a machine scratch register, a machine status register, a fixed ISA description register and a free-running cycle counter. The decode stage gives it an operation code, a form flag (register source or 5-bit immediate), a 12-bit register address, the source operand, the immediate, a flag that is set when the source is x0 or the immediate is zero, and the current privilege level.

The old value of the addressed register comes back combinationally on the same cycle, for write-back to the destination register. The new value is committed at the next rising clock edge. The unit raises an illegal-instruction flag in three cases: the access writes a read-only register, the privilege is too low, or the address or operation code is not implemented. When the flag is raised, no register state changes and the destination write-enable stays low.

A set or clear whose mask comes from x0, or from a zero immediate, counts as a pure read. Such an access may therefore read a read-only register without trapping.

Top module: `csr_unit`

## Requirements
- R1: A legal access (`op_valid` high, `illegal` low) drives `rd_we` high and returns on `rd_value`, in the same cycle, the value the register held before the access.
- R2: Operation code 2'b01 (write) replaces the register with the operand at the next rising edge.
- R3: Operation code 2'b10 (set) ORs the operand into the register.
- R4: Operation code 2'b11 (clear) ANDs the register with the inverted operand.
- R5: When `op_imm` is 1, the operand is `imm5` zero-extended to XLEN bits, and `src_value` is ignored.
- R6: Address bits [11:10] = 2'b11 mark a register as read-only. A write, or a set or clear with a nonzero mask, to such an address raises `illegal` and leaves `rd_we` low. The cycle counter is at address 0xC00.
- R7: Address bits [9:8] give the lowest privilege allowed (user 2'b00, supervisor 2'b01, machine 2'b11). An access from a lower `priv` raises `illegal`. Status (0x300), ISA (0x301) and scratch (0x340) need machine level.
- R8: A set or clear with `src_zero` high writes nothing. It is legal on a read-only register.
- R9: An address outside {0x300, 0x301, 0x340, 0xC00}, or operation code 2'b00, raises `illegal`. An access that raises `illegal` changes no register.
- R10: The cycle counter is 0 in reset and rises by exactly one on every clock edge after reset.
- R11: The ISA register reads as a constant, and writes to it are ignored. Bit 20 reflects `USER_PRESENT`, bit 8 is set, and the top field encodes XLEN (bits 63:62 = 2'b10 for 64 bits).
- R12: Status bits [33:32] always read 2'b10 when XLEN is 64 and `USER_PRESENT` is 1, and 2'b00 otherwise. All other status bits are writable.
- R13: While `rst_n` is low, scratch and the writable status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronized to `clk` on release |
| op_valid | input | 1 | A register instruction is presented this cycle |
| op_code | input | 2 | 01 write, 10 set, 11 clear, 00 reserved |
| op_imm | input | 1 | 1 selects the immediate form |
| csr_addr | input | 12 | Register address |
| src_value | input | XLEN | Source register operand |
| imm5 | input | 5 | Immediate operand |
| src_zero | input | 1 | Source is x0, or the immediate is zero |
| priv | input | 2 | Current privilege level |
| rd_value | output | XLEN | Old register value for the destination |
| rd_we | output | 1 | Destination write-enable |
| illegal | output | 1 | Illegal-instruction exception |

## Verification
The assertions assume that `src_zero` agrees with the operand the decoder actually chose: high only when `imm5` is zero in immediate form, or when the source is x0 in register form. They also assume that `priv` never takes the reserved value 2'b10. The bench derives `src_zero` from the immediate in every immediate-form call and uses only privilege codes 00, 01 and 11. The address and operation code, by contrast, are driven with unmapped and reserved values on purpose, so that the trap paths are exercised.

// File: rtl/csr_pkg.sv
package csr_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;

  typedef enum logic [1:0] {
    SEL_SCRATCH = 2'd0,
    SEL_STATUS  = 2'd1,
    SEL_ISA     = 2'd2,
    SEL_CYCLE   = 2'd3
  } csr_sel_e;

  localparam logic [11:0] ADDR_STATUS  = 12'h300;
  localparam logic [11:0] ADDR_ISA     = 12'h301;
  localparam logic [11:0] ADDR_SCRATCH = 12'h340;
  localparam logic [11:0] ADDR_CYCLE   = 12'hC00;
endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_pkg::*;
(
  input  logic        valid_i,
  input  csr_op_e     op_i,
  input  logic [11:0] addr_i,
  input  logic [1:0]  priv_i,
  input  logic        src_zero_i,
  output csr_sel_e    sel_o,
  output logic        wr_req_o,
  output logic        illegal_o
);
  logic hit;
  logic read_only;
  logic priv_low;
  logic modifies;

  always_comb begin
    hit   = 1'b1;
    sel_o = SEL_SCRATCH;
    unique case (addr_i)
      ADDR_SCRATCH: sel_o = SEL_SCRATCH;
      ADDR_STATUS:  sel_o = SEL_STATUS;
      ADDR_ISA:     sel_o = SEL_ISA;
      ADDR_CYCLE:   sel_o = SEL_CYCLE;
      default:      hit   = 1'b0;
    endcase
  end

  always_comb begin
    read_only = (addr_i[11:10] == 2'b11);
    priv_low  = (priv_i < addr_i[9:8]);
    modifies  = (op_i == OP_WRITE) ||
                (((op_i == OP_SET) || (op_i == OP_CLEAR)) && !src_zero_i);
    illegal_o = valid_i && ((op_i == OP_NONE) || !hit || priv_low ||
                            (read_only && modifies));
    wr_req_o  = valid_i && modifies && !illegal_o;
  end
endmodule

// File: rtl/csr_alu.sv
module csr_alu
  import csr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  csr_op_e          op_i,
  input  logic [XLEN-1:0]  old_i,
  input  logic [XLEN-1:0]  operand_i,
  output logic [XLEN-1:0]  new_o
);
  always_comb begin
    unique case (op_i)
      OP_WRITE: new_o = operand_i;
      OP_SET:   new_o = old_i | operand_i;
      OP_CLEAR: new_o = old_i & ~operand_i;
      default:  new_o = old_i;
    endcase
  end
endmodule

// File: rtl/csr_regfile.sv
module csr_regfile
  import csr_pkg::*;
#(
  parameter int XLEN         = 64,
  parameter bit USER_PRESENT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  csr_sel_e        sel_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o
);
  localparam logic [XLEN-1:0] ONE        = {{(XLEN-1){1'b0}}, 1'b1};
  localparam logic [XLEN-1:0] FIXED_MASK = (XLEN > 32) ? ((ONE << 32) | (ONE << 33)) : '0;
  localparam logic [XLEN-1:0] UXL_VAL    = ((XLEN > 32) && USER_PRESENT) ? (ONE << 33) : '0;
  localparam logic [XLEN-1:0] MXL_VAL    = (XLEN == 64) ? (ONE << (XLEN-1)) : (ONE << (XLEN-2));
  localparam logic [XLEN-1:0] ISA_VAL    = MXL_VAL | (ONE << 8) |
                                           (USER_PRESENT ? (ONE << 20) : '0);

  logic [XLEN-1:0] scratch_q, scratch_d;
  logic [XLEN-1:0] status_q,  status_d;
  logic [XLEN-1:0] cycle_q,   cycle_d;
  logic            scratch_en, status_en;

  always_comb begin
    scratch_en = wr_en_i && (sel_i == SEL_SCRATCH);
    status_en  = wr_en_i && (sel_i == SEL_STATUS);
    scratch_d  = wdata_i;
    status_d   = wdata_i & ~FIXED_MASK;
    cycle_d    = cycle_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
      status_q  <= '0;
      cycle_q   <= '0;
    end else begin
      if (scratch_en) scratch_q <= scratch_d;
      if (status_en)  status_q  <= status_d;
      cycle_q <= cycle_d;
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_SCRATCH: rdata_o = scratch_q;
      SEL_STATUS:  rdata_o = status_q | UXL_VAL;
      SEL_ISA:     rdata_o = ISA_VAL;
      default:     rdata_o = cycle_q;
    endcase
  end

  // R10: counter advances by one each cycle out of reset
  p_cycle_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cycle_q == $past(cycle_q) + ONE));

  // R9: without a commit the stored registers hold
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ($stable(scratch_q) && $stable(status_q)));

  // R2: a committed scratch write lands on the next edge
  p_scratch_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && sel_i == SEL_SCRATCH) |=> (scratch_q == $past(wdata_i)));
endmodule

// File: rtl/csr_unit.sv
module csr_unit
  import csr_pkg::*;
#(
  parameter int XLEN         = 64,
  parameter bit USER_PRESENT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [1:0]      op_code,
  input  logic            op_imm,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] src_value,
  input  logic [4:0]      imm5,
  input  logic            src_zero,
  input  logic [1:0]      priv,
  output logic [XLEN-1:0] rd_value,
  output logic            rd_we,
  output logic            illegal
);
  csr_op_e         op;
  csr_sel_e        sel;
  logic            wr_req;
  logic [XLEN-1:0] operand;
  logic [XLEN-1:0] old_val;
  logic [XLEN-1:0] new_val;

  assign op      = csr_op_e'(op_code);
  assign operand = op_imm ? {{(XLEN-5){1'b0}}, imm5} : src_value;

  csr_decode u_decode (
    .valid_i    (op_valid),
    .op_i       (op),
    .addr_i     (csr_addr),
    .priv_i     (priv),
    .src_zero_i (src_zero),
    .sel_o      (sel),
    .wr_req_o   (wr_req),
    .illegal_o  (illegal)
  );

  csr_alu #(.XLEN(XLEN)) u_alu (
    .op_i      (op),
    .old_i     (old_val),
    .operand_i (operand),
    .new_o     (new_val)
  );

  csr_regfile #(.XLEN(XLEN), .USER_PRESENT(USER_PRESENT)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_req),
    .sel_i   (sel),
    .wdata_i (new_val),
    .rdata_o (old_val)
  );

  assign rd_value = old_val;
  assign rd_we    = op_valid && !illegal;

  // R6: a plain write to a read-only address must trap
  p_ro_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && csr_addr[11:10] == 2'b11 && op_code == 2'b01) |-> illegal);

  // R7: privilege below the address field must trap
  p_priv_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && priv < csr_addr[9:8]) |-> (illegal && !rd_we));

  // R8: a set or clear with a zero mask on the counter is legal in machine mode
  p_zero_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && csr_addr == ADDR_CYCLE && op_code[1] && src_zero && priv == 2'b11) |-> !illegal);
endmodule

// File: tb/csr_unit_test.sv
module csr_unit_test;
  localparam int XLEN = 64;
  localparam logic [1:0] U = 2'b00, S = 2'b01, M = 2'b11;
  localparam logic [1:0] WR = 2'b01, ST = 2'b10, CL = 2'b11, NO = 2'b00;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            op_valid;
  logic [1:0]      op_code;
  logic            op_imm;
  logic [11:0]     csr_addr;
  logic [XLEN-1:0] src_value;
  logic [4:0]      imm5;
  logic            src_zero;
  logic [1:0]      priv;
  logic [XLEN-1:0] rd_value;
  logic            rd_we;
  logic            illegal;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  csr_unit #(.XLEN(XLEN), .USER_PRESENT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_imm(op_imm), .csr_addr(csr_addr), .src_value(src_value), .imm5(imm5),
    .src_zero(src_zero), .priv(priv), .rd_value(rd_value), .rd_we(rd_we),
    .illegal(illegal)
  );

  task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Presents one access at a falling edge and samples the outputs just after.
  task automatic do_op(string tag, logic [1:0] code, bit imm, logic [11:0] addr,
                       logic [XLEN-1:0] src, logic [4:0] i5, bit is_x0, logic [1:0] prv,
                       bit exp_ill, bit chk_val, logic [XLEN-1:0] exp_old);
    @(negedge clk);
    op_valid  = 1'b1;
    op_code   = code;
    op_imm    = imm;
    csr_addr  = addr;
    src_value = src;
    imm5      = i5;
    src_zero  = imm ? (i5 == 5'd0) : is_x0;
    priv      = prv;
    #1;
    chk({tag, " illegal"}, {63'd0, illegal}, {63'd0, exp_ill});
    chk({tag, " rd_we"},   {63'd0, rd_we},   {63'd0, !exp_ill});
    if (chk_val && !exp_ill) chk({tag, " rd_value"}, rd_value, exp_old);
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_op("R13 scratch in reset", ST, 0, 12'h340, 0, 0, 1, M, 0, 1, 64'h0);
    do_op("R10 cycle in reset",   ST, 0, 12'hC00, 0, 0, 1, M, 0, 1, 64'h0);
    do_op("R13 status in reset",  ST, 0, 12'h300, 0, 0, 1, M, 0, 1, 64'h0000_0002_0000_0000);
    @(negedge clk);
    op_valid = 1'b0;
    rst_n    = 1'b1;
  endtask

  task automatic t_rmw_imm();
    do_op("R2 write 3",         WR, 0, 12'h340, 64'd3, 0, 0, M, 0, 1, 64'd0);
    do_op("R8 read via x0 set", ST, 0, 12'h340, 64'hFF, 0, 1, M, 0, 1, 64'd3);
    do_op("R4 R5 clear imm 1",  CL, 1, 12'h340, 64'hFFFF, 5'd1, 0, M, 0, 1, 64'd3);
    do_op("R3 R5 set imm 4",    ST, 1, 12'h340, 64'hFFFF, 5'd4, 0, M, 0, 1, 64'd2);
    do_op("R2 R5 write imm 2",  WR, 1, 12'h340, 64'hFFFF, 5'd2, 0, M, 0, 1, 64'd6);
    do_op("R1 read back 2",     ST, 1, 12'h340, 0, 5'd0, 0, M, 0, 1, 64'd2);
    do_op("R5 write imm 31",    WR, 1, 12'h340, {XLEN{1'b1}}, 5'd31, 0, M, 0, 1, 64'd2);
    do_op("R5 zero-extended",   ST, 1, 12'h340, 0, 5'd0, 0, M, 0, 1, 64'd31);
  endtask

  task automatic t_rmw_reg();
    do_op("R2 write bad1dea",   WR, 0, 12'h340, 64'h0BAD1DEA, 0, 0, M, 0, 1, 64'd31);
    do_op("R4 clear 1dea",      CL, 0, 12'h340, 64'h0001DEA, 0, 0, M, 0, 1, 64'h0BAD1DEA);
    do_op("R3 set beef",        ST, 0, 12'h340, 64'h000BEEF, 0, 0, M, 0, 1, 64'h0BAD0000);
    do_op("R1 read badbeef",    CL, 0, 12'h340, 0, 0, 1, M, 0, 1, 64'h0BADBEEF);
  endtask

  task automatic t_readonly();
    do_op("R6 write counter",      WR, 0, 12'hC00, 64'd255, 0, 0, M, 1, 0, 0);
    do_op("R6 set-imm counter",    ST, 1, 12'hC00, 0, 5'd3, 0, M, 1, 0, 0);
    do_op("R8 set x0 counter user",ST, 0, 12'hC00, 64'd7, 0, 1, U, 0, 0, 0);
    do_op("R8 clear imm0 counter", CL, 1, 12'hC00, 0, 5'd0, 0, M, 0, 0, 0);
    do_op("R6 scratch untouched",  ST, 0, 12'h340, 0, 0, 1, M, 0, 1, 64'h0BADBEEF);
  endtask

  task automatic t_privilege();
    do_op("R7 status from user",     ST, 0, 12'h300, 0, 0, 1, U, 1, 0, 0);
    do_op("R7 status from super",    ST, 0, 12'h300, 0, 0, 1, S, 1, 0, 0);
    do_op("R7 scratch write user",   WR, 0, 12'h340, 64'd1, 0, 0, U, 1, 0, 0);
    do_op("R7 scratch kept",         ST, 0, 12'h340, 0, 0, 1, M, 0, 1, 64'h0BADBEEF);
  endtask

  task automatic t_status_isa();
    do_op("R12 status write ones", WR, 0, 12'h300, {XLEN{1'b1}}, 0, 0, M, 0, 1, 64'h0000_0002_0000_0000);
    do_op("R12 status clear ones", CL, 0, 12'h300, {XLEN{1'b1}}, 0, 0, M, 0, 1, 64'hFFFF_FFFE_FFFF_FFFF);
    do_op("R12 status after clear",ST, 0, 12'h300, 0, 0, 1, M, 0, 1, 64'h0000_0002_0000_0000);
    do_op("R11 isa read",          ST, 0, 12'h301, 0, 0, 1, M, 0, 1, 64'h8000_0000_0010_0100);
    do_op("R11 isa write zero",    WR, 0, 12'h301, 64'd0, 0, 0, M, 0, 1, 64'h8000_0000_0010_0100);
    do_op("R11 isa unchanged",     ST, 0, 12'h301, 0, 0, 1, M, 0, 1, 64'h8000_0000_0010_0100);
  endtask

  task automatic t_unmapped();
    do_op("R9 unmapped address",   ST, 0, 12'h7C0, 0, 0, 1, M, 1, 0, 0);
    do_op("R9 reserved op",        NO, 0, 12'h340, {XLEN{1'b1}}, 0, 0, M, 1, 0, 0);
    do_op("R9 unmapped write",     WR, 0, 12'h341, 64'd5, 0, 0, M, 1, 0, 0);
    do_op("R9 scratch unchanged",  ST, 0, 12'h340, 0, 0, 1, M, 0, 1, 64'h0BADBEEF);
  endtask

  task automatic t_cycle();
    logic [XLEN-1:0] first;
    do_op("R10 counter read a", ST, 0, 12'hC00, 0, 0, 1, M, 0, 0, 0);
    first = rd_value;
    for (int i = 0; i < 9; i++) idle();
    do_op("R10 counter read b", ST, 0, 12'hC00, 0, 0, 1, M, 0, 0, 0);
    chk("R10 counter delta", rd_value - first, 64'd10);
  endtask

  initial begin
    #500000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = 2'b00; op_imm = 1'b0;
    csr_addr = '0; src_value = '0; imm5 = '0; src_zero = 1'b0; priv = M;
    repeat (2) @(negedge clk);
    t_reset();
    t_rmw_imm();
    t_rmw_reg();
    t_readonly();
    t_privilege();
    t_status_isa();
    t_unmapped();
    t_cycle();
    idle();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule